// File: doc/BRIEF.md
# Mixed-Width Block RAM With Byte-Lane Writes

This block is a synchronous memory with one write port and one read port that look at the same flat array of bits through different word widths. A producer can, for example, write 32-bit words while a consumer reads the same storage back as bytes. Every control and data input passes through an input register before it reaches the array. A small register holds the array read result, and a second register on the output can be switched on or off by a parameter.

The write port can update any subset of its 8-bit lanes (10-bit lanes for the 5/10/20/40 width family). Write and read requests are independent. When no read is requested, the data output keeps its previous value, so it does not toggle. One clock enable gates the input registers and the array. A second clock enable gates the output register. At start-up the array holds either all zeros or an arithmetic pattern set by parameters.

Top module: `mixwidth_ram`

## Requirements
- R1: Inputs act only after they are registered. A read accepted at clock edge n loads the array result into the core read register at edge n+1.
- R2: With `OUT_REG`=1, the read result appears on `rdata` after edge n+2. A sample taken after edge n+1 still shows the previous value. With `OUT_REG`=0, the result appears after edge n+1.
- R3: While `ce_in` is low, the input registers, the array and the core read register hold their state. A write or read presented during that time has no effect.
- R4: While `ce_out` is low (with `OUT_REG`=1), `rdata` holds its value. When `ce_out` returns high, the pending core result is loaded on the next edge.
- R5: When the registered read request is low, `rdata` keeps its last value. A write issued in the same cycles still updates the array.
- R6: Write lane i covers bits [i*LANE_W +: LANE_W] of `wdata` and is written only if `wbe[i]`=1. A write with `wbe`=0 changes nothing. If `WR_W` < `LANE_W`, `wbe` is ignored and `we` alone writes the word.
- R7: Write word w occupies array bits [w*WR_W +: WR_W] and read word r occupies bits [r*RD_W +: RD_W]. A narrower port's lower addresses therefore map to the less significant bits of the wider word.
- R8: If a read and a write reach the array in the same cycle and overlap, the read returns the data stored before the write.
- R9: With `INIT_PATTERN`=1, write word k starts as (`INIT_BASE` + k*`INIT_STEP`) truncated to `WR_W` bits. With `INIT_PATTERN`=0, the array starts as all zeros.
- R10: While `rst_n` is low, `rdata` is 0 and the registered write and read requests are cleared. The array contents are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline registers |
| ce_in | input | 1 | Clock enable for the input registers, the array and the core read register |
| ce_out | input | 1 | Clock enable for the optional output register |
| we | input | 1 | Write request |
| waddr | input | WA | Write word address |
| wdata | input | WR_W | Write data |
| wbe | input | NBE | Write lane enables, one bit per lane |
| re | input | 1 | Read request |
| raddr | input | RA | Read word address |
| rdata | output | RD_W | Read data |

## Verification
The bench uses a 32-bit write port and an 8-bit read port. It checks that each byte read back comes from the expected lane of the expected write word. A design that swapped the lane order or scaled an address wrongly would return another byte of the pattern. It issues partial and empty lane masks, which a design that ignored `wbe` would turn into full-word writes. It also collides a read with a write to the same word, where a write-first array would return the new data. Finally, it holds each clock enable low while presenting requests and checks at the port that neither the array nor `rdata` moved. It measures the exact read latency, which catches a design that drops or doubles the output stage.

// File: rtl/mwr_pkg.sv
package mwr_pkg;

  // Lanes on the write port; a port narrower than one lane has a single enable.
  function automatic int lanes_of(input int width, input int lane_w);
    return (width >= lane_w) ? width / lane_w : 1;
  endfunction

  // Address width for a port of the given width over the whole array.
  function automatic int addr_bits(input int total, input int width);
    return (total / width > 1) ? $clog2(total / width) : 1;
  endfunction

  // Start-up content of write word idx.
  function automatic logic [63:0] pattern_word(input int idx, input logic [63:0] base,
                                               input logic [63:0] step);
    return base + 64'(idx) * step;
  endfunction

endpackage

// File: rtl/mwr_in_stage.sv
module mwr_in_stage #(
  parameter int WR_W = 32,
  parameter int WA   = 8,
  parameter int RA   = 10,
  parameter int NBE  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ce,
  input  logic            we,
  input  logic [WA-1:0]   waddr,
  input  logic [WR_W-1:0] wdata,
  input  logic [NBE-1:0]  wbe,
  input  logic            re,
  input  logic [RA-1:0]   raddr,
  output logic            we_q,
  output logic [WA-1:0]   waddr_q,
  output logic [WR_W-1:0] wdata_q,
  output logic [NBE-1:0]  wbe_q,
  output logic            re_q,
  output logic [RA-1:0]   raddr_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q    <= 1'b0;
      re_q    <= 1'b0;
      waddr_q <= '0;
      raddr_q <= '0;
      wdata_q <= '0;
      wbe_q   <= '0;
    end else if (ce) begin
      we_q    <= we;
      re_q    <= re;
      waddr_q <= waddr;
      raddr_q <= raddr;
      wdata_q <= wdata;
      wbe_q   <= wbe;
    end
  end

  // R3: a stalled input stage keeps every captured field
  a_r3_capture_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable({we_q, re_q, waddr_q, raddr_q, wdata_q, wbe_q}));

endmodule

// File: rtl/mwr_core.sv
module mwr_core #(
  parameter int          TOTAL_BITS   = 8192,
  parameter int          WR_W         = 32,
  parameter int          RD_W         = 8,
  parameter int          LANE_W       = 8,
  parameter int          NBE          = 4,
  parameter int          WA           = 8,
  parameter int          RA           = 10,
  parameter bit          INIT_PATTERN = 1'b1,
  parameter logic [63:0] INIT_BASE    = 64'h1357_9BDF,
  parameter logic [63:0] INIT_STEP    = 64'h0102_0408
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ce,
  input  logic            we_q,
  input  logic [WA-1:0]   waddr_q,
  input  logic [WR_W-1:0] wdata_q,
  input  logic [NBE-1:0]  wbe_q,
  input  logic            re_q,
  input  logic [RA-1:0]   raddr_q,
  output logic [RD_W-1:0] core_dat
);
  import mwr_pkg::*;

  localparam int BW       = $clog2(TOTAL_BITS);
  localparam int WR_DEPTH = TOTAL_BITS / WR_W;

  function automatic logic [TOTAL_BITS-1:0] build_image();
    logic [TOTAL_BITS-1:0] v = '0;
    if (INIT_PATTERN)
      for (int k = 0; k < WR_DEPTH; k++)
        v[k*WR_W +: WR_W] = WR_W'(pattern_word(k, INIT_BASE, INIT_STEP));
    return v;
  endfunction

  // Bit mask of the write word selected by the lane enables.
  function automatic logic [WR_W-1:0] lane_mask(input logic [NBE-1:0] be);
    logic [WR_W-1:0] m;
    for (int b = 0; b < WR_W; b++)
      m[b] = (WR_W < LANE_W) ? 1'b1 : be[b / LANE_W];
    return m;
  endfunction

  logic [TOTAL_BITS-1:0] mem = build_image();

  // Named internal events for the checks below.
  logic            wr_fire, rd_fire;
  logic [BW-1:0]   wbit, rbit;
  logic [WR_W-1:0] wmask, cur_w;
  logic [RD_W-1:0] cur_r;

  assign wr_fire = ce & we_q;
  assign rd_fire = ce & re_q;
  assign wbit    = BW'(waddr_q) * BW'(WR_W);
  assign rbit    = BW'(raddr_q) * BW'(RD_W);
  assign wmask   = lane_mask(wbe_q);
  assign cur_w   = mem[wbit +: WR_W];
  assign cur_r   = mem[rbit +: RD_W];

  always_ff @(posedge clk) begin
    if (wr_fire) mem[wbit +: WR_W] <= (cur_w & ~wmask) | (wdata_q & wmask);
  end

  // Read sees the array before this edge's write: old data on collision.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       core_dat <= '0;
    else if (rd_fire) core_dat <= cur_r;
  end

  // R6: enabled lanes take the new data
  a_r6_lanes_written: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> ((mem[$past(wbit) +: WR_W] & $past(wmask)) == ($past(wdata_q) & $past(wmask))));

  // R6: disabled lanes keep their old contents
  a_r6_lanes_kept: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> ((mem[$past(wbit) +: WR_W] & ~$past(wmask)) == ($past(cur_w) & ~$past(wmask))));

  // R8: an overlapping read in the write cycle returns pre-write data
  a_r8_old_on_collision: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && wr_fire && (rbit / BW'(WR_W) == wbit / BW'(WR_W)))
      |=> core_dat == $past(cur_r));

  // R5, R3: no read request or a stalled core leaves the read register alone
  a_r5_core_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> $stable(core_dat));

endmodule

// File: rtl/mwr_out_stage.sv
module mwr_out_stage #(
  parameter int RD_W    = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ce,
  input  logic [RD_W-1:0] core_dat,
  output logic [RD_W-1:0] rdata
);

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  rdata <= '0;
        else if (ce) rdata <= core_dat;
      end

      // R4: a stalled output register holds
      a_r4_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> $stable(rdata));

      // R2: an enabled output register shows the core result one edge later
      a_r2_out_follow: assert property (@(posedge clk) disable iff (!rst_n)
        ce |=> rdata == $past(core_dat));
    end else begin : g_thru
      logic unused_ce;
      assign unused_ce = ce;
      assign rdata     = core_dat;
    end
  endgenerate

endmodule

// File: rtl/mixwidth_ram.sv
module mixwidth_ram #(
  parameter int          TOTAL_BITS   = 8192,
  parameter int          WR_W         = 32,
  parameter int          RD_W         = 8,
  parameter int          LANE_W       = 8,
  parameter bit          OUT_REG      = 1'b1,
  parameter bit          INIT_PATTERN = 1'b1,
  parameter logic [63:0] INIT_BASE    = 64'h1357_9BDF,
  parameter logic [63:0] INIT_STEP    = 64'h0102_0408,
  localparam int         NBE          = mwr_pkg::lanes_of(WR_W, LANE_W),
  localparam int         WA           = mwr_pkg::addr_bits(TOTAL_BITS, WR_W),
  localparam int         RA           = mwr_pkg::addr_bits(TOTAL_BITS, RD_W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ce_in,
  input  logic            ce_out,
  input  logic            we,
  input  logic [WA-1:0]   waddr,
  input  logic [WR_W-1:0] wdata,
  input  logic [NBE-1:0]  wbe,
  input  logic            re,
  input  logic [RA-1:0]   raddr,
  output logic [RD_W-1:0] rdata
);

  logic            we_q, re_q;
  logic [WA-1:0]   waddr_q;
  logic [RA-1:0]   raddr_q;
  logic [WR_W-1:0] wdata_q;
  logic [NBE-1:0]  wbe_q;
  logic [RD_W-1:0] core_dat;

  mwr_in_stage #(.WR_W(WR_W), .WA(WA), .RA(RA), .NBE(NBE)) u_in (
    .clk(clk), .rst_n(rst_n), .ce(ce_in),
    .we(we), .waddr(waddr), .wdata(wdata), .wbe(wbe), .re(re), .raddr(raddr),
    .we_q(we_q), .waddr_q(waddr_q), .wdata_q(wdata_q), .wbe_q(wbe_q),
    .re_q(re_q), .raddr_q(raddr_q)
  );

  mwr_core #(
    .TOTAL_BITS(TOTAL_BITS), .WR_W(WR_W), .RD_W(RD_W), .LANE_W(LANE_W), .NBE(NBE),
    .WA(WA), .RA(RA), .INIT_PATTERN(INIT_PATTERN), .INIT_BASE(INIT_BASE),
    .INIT_STEP(INIT_STEP)
  ) u_core (
    .clk(clk), .rst_n(rst_n), .ce(ce_in),
    .we_q(we_q), .waddr_q(waddr_q), .wdata_q(wdata_q), .wbe_q(wbe_q),
    .re_q(re_q), .raddr_q(raddr_q), .core_dat(core_dat)
  );

  mwr_out_stage #(.RD_W(RD_W), .OUT_REG(OUT_REG)) u_out (
    .clk(clk), .rst_n(rst_n), .ce(ce_out), .core_dat(core_dat), .rdata(rdata)
  );

  // R10: reset clears the visible read data and the pending requests
  a_r10_reset_clear: assert property (@(posedge clk)
    !rst_n |-> (rdata == '0 && !we_q && !re_q));

endmodule

// File: tb/test_mixwidth_ram.sv
`timescale 1ns/1ps
module test_mixwidth_ram;
  localparam int LAT = 3;  // capture + core read + output register

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_in = 1'b1, ce_out = 1'b1;
  logic        we = 1'b0, re = 1'b0;
  logic [7:0]  waddr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  wbe = '0;
  logic [9:0]  raddr = '0;
  logic [7:0]  rdata;

  mixwidth_ram #(
    .TOTAL_BITS(8192), .WR_W(32), .RD_W(8), .LANE_W(8), .OUT_REG(1'b1),
    .INIT_PATTERN(1'b1), .INIT_BASE(64'h1357_9BDF), .INIT_STEP(64'h0102_0408)
  ) i_mixwidth_ram (
    .clk(clk), .rst_n(rst_n), .ce_in(ce_in), .ce_out(ce_out), .we(we),
    .waddr(waddr), .wdata(wdata), .wbe(wbe), .re(re), .raddr(raddr), .rdata(rdata)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc++;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  logic [8191:0] model;
  logic [7:0]    last_rd = 8'h00;

  int         q_due[$];
  logic [7:0] q_val[$];
  string      q_tag[$];

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: rdata=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Monitor: pop scoreboard entries as their cycle comes due.
  always @(negedge clk) begin
    if (rst_n) begin
      while (q_due.size() > 0 && q_due[0] == cyc) begin
        chk(q_tag[0], rdata, q_val[0]);
        void'(q_due.pop_front());
        void'(q_val.pop_front());
        void'(q_tag.pop_front());
      end
    end
  end

  // Driver: one request per cycle, expectation pushed before the model write.
  task automatic op(input logic w, input int wa, input logic [31:0] wd, input logic [3:0] be,
                    input logic r, input int ra, input string tag);
    @(negedge clk);
    ce_in = 1'b1; ce_out = 1'b1;
    we = w; waddr = 8'(wa); wdata = wd; wbe = be; re = r; raddr = 10'(ra);
    if (r) last_rd = model[ra*8 +: 8];
    q_due.push_back(cyc + LAT);
    q_val.push_back(last_rd);
    q_tag.push_back(tag);
    if (w)
      for (int i = 0; i < 4; i++)
        if (be[i]) model[(wa*32) + (i*8) +: 8] = wd[i*8 +: 8];
  endtask

  task automatic rd(input int ra, input string tag);
    op(1'b0, 0, 32'h0, 4'h0, 1'b1, ra, tag);
  endtask

  task automatic settle();
    @(negedge clk);
    we = 1'b0; re = 1'b0;
    repeat (LAT + 1) @(negedge clk);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    report();
  end

  initial begin
    // R9 start-up image computed from the stated formula
    for (int k = 0; k < 256; k++) model[k*32 +: 32] = 32'h1357_9BDF + 32'(k) * 32'h0102_0408;

    // R10: reset state
    repeat (3) @(negedge clk);
    chk("R10", rdata, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", rdata, 8'h00);

    // R9, R7: start-up pattern and byte order of the narrow port
    rd(0, "R9"); rd(1, "R7"); rd(2, "R7"); rd(3, "R7");
    rd(5, "R9"); rd(1023, "R9"); rd(514, "R7");

    // R6, R7: full write, then partial and empty lane masks
    op(1'b1, 10, 32'hDEAD_BEEF, 4'hF, 1'b0, 0, "R5");
    rd(40, "R7"); rd(41, "R7"); rd(42, "R7"); rd(43, "R7");
    op(1'b1, 10, 32'h1122_3344, 4'h5, 1'b0, 0, "R5");
    rd(40, "R6"); rd(41, "R6"); rd(42, "R6"); rd(43, "R6");
    op(1'b1, 10, 32'h99AA_BBCC, 4'h0, 1'b0, 0, "R5");
    rd(40, "R6"); rd(43, "R6");

    // R8: same-cycle read and write of one word returns old data
    op(1'b1, 20, 32'hA5A5_5A5A, 4'hF, 1'b1, 80, "R8");
    rd(80, "R8");
    // write then read in the next cycle sees the new data
    op(1'b1, 21, 32'h0F1E_2D3C, 4'hF, 1'b0, 0, "R5");
    rd(85, "R7");

    // R5: read disabled holds rdata while writes still land
    rd(40, "R5");
    op(1'b1, 10, 32'h7766_5544, 4'hF, 1'b0, 0, "R5");
    op(1'b0, 0, 32'h0, 4'h0, 1'b0, 0, "R5");
    rd(40, "R5");
    settle();

    // R1, R2: exact read latency
    begin
      logic [7:0] old_v, new_v;
      old_v = last_rd;
      new_v = model[7*8 +: 8];
      @(negedge clk); re = 1'b1; raddr = 10'd7;
      @(negedge clk); re = 1'b0;
      chk("R1", rdata, old_v);
      @(negedge clk); chk("R2", rdata, old_v);
      @(negedge clk); chk("R2", rdata, new_v);
      last_rd = new_v;
    end
    settle();

    // R4: output clock enable low freezes rdata
    begin
      logic [7:0] old_v, new_v;
      old_v = last_rd;
      new_v = model[9*8 +: 8];
      @(negedge clk); ce_out = 1'b0; re = 1'b1; raddr = 10'd9;
      @(negedge clk); re = 1'b0;
      repeat (3) @(negedge clk);
      chk("R4", rdata, old_v);
      ce_out = 1'b1;
      @(negedge clk); chk("R4", rdata, new_v);
      last_rd = new_v;
    end
    settle();

    // R3: input clock enable low drops a presented write and read
    begin
      logic [7:0] old_v;
      old_v = last_rd;
      @(negedge clk);
      ce_in = 1'b0; we = 1'b1; waddr = 8'd50; wdata = 32'hCAFE_F00D; wbe = 4'hF;
      re = 1'b1; raddr = 10'd200;
      repeat (4) @(negedge clk);
      chk("R3", rdata, old_v);
      we = 1'b0; re = 1'b0; ce_in = 1'b1;
    end
    rd(200, "R3"); rd(203, "R3");
    settle();

    report();
  end
endmodule